// File: doc/BRIEF.md
# Compare-Match Timer with Toggle Output

This block is an 8-bit up counter with a compare register, meant for periodic interrupts and square-wave generation. One of four count-source pulse inputs is selected, and a power-of-two prescaler thins it out. Each surviving pulse advances the counter by one step while the timer is enabled. On every step the current count is compared with the compare register. A match, or the wrap from the top value to zero, is an event. Per-event control bits decide what each event does: clear the counter (on match), toggle the square-wave output, or latch an interrupt flag.

The square-wave output comes from a toggle flip-flop. A one-cycle stage pulse marks every cycle in which it toggles. While the timer is stopped, software can load a start level into the flip-flop. Two sticky flags, compare and overflow, are cleared by writing 1. Each flag is gated by a mask bit onto its own interrupt line.

Everything runs on one clock. The source inputs are clock-enable pulses, not clocks. Registers are reached through a synchronous write strobe and a combinational read port.

Top module: `cmp_toggle_timer`

## Requirements
- R1: After reset the count, control, mode, compare, mask and flag registers read 0. The wave output, the stage pulse and both interrupt lines are low.
- R2: While the run bit (control bit 0) is 1, the count advances by one on each prescaler output pulse. Only the source chosen by mode bits [1:0] is counted; pulses on the other three source inputs have no effect on the count.
- R3: With the exponent k in mode bits [5:2], the count advances once for every 2^k pulses of the selected source. The prescaler phase restarts from zero whenever the run bit is 0.
- R4: While the run bit is 0, the count holds its value and all source pulses are ignored.
- R5: Without a compare clear, the count runs 0..255 and wraps to 0. The step from 255 to 0 is an overflow event.
- R6: With clear-on-compare (control bit 2) set, a step taken while count equals the compare register (address 2) loads 0 instead of incrementing. The period is then compare+1 steps. Such a step is not an overflow.
- R7: The wave output inverts, and the stage pulse is high for one cycle, in the clock cycle after a step that holds an enabled toggle event. Toggle on compare is control bit 3; toggle on overflow is control bit 4. In any other cycle the wave holds and the stage pulse is low.
- R8: The compare flag (bit 0 at address 4) and the overflow flag (bit 1) are set by their event when the matching control bit is 1 (bit 5 for compare, bit 6 for overflow). They stay set until a 1 is written to that bit. Writing 0 leaves a flag alone. An event in the same cycle as a clear leaves the flag set.
- R9: The compare interrupt line equals the compare flag AND mask bit 0 (address 5). The overflow line equals the overflow flag AND mask bit 1.
- R10: Control bit 1 is the preset level. A write to the control register (address 0) while the run bit is 0 loads the wave output from that bit. The same write while running leaves the wave output unchanged.
- R11: The compare register may be rewritten while running. The next step is compared against the new value.
- R12: The count is read at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all state |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 4 | One-cycle enable pulses of the four count sources |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| wave_out | output | 1 | Toggle flip-flop output |
| stage_clk | output | 1 | One-cycle pulse in each cycle the wave toggles |
| irq_cmp | output | 1 | Masked compare interrupt |
| irq_ovf | output | 1 | Masked overflow interrupt |

## Verification
A sweep over every source select and the exponents 0 to 2 interleaves pulses on the unselected sources with pulses on the selected one. This separates source selection from prescaler division. A full free-running lap of 256 steps with only the overflow actions enabled exposes wrap detection and shows that compare events leave no trace when their actions are off. Clear-on-compare runs over compare values from 0 through 255 check the period compare+1 and an arithmetically derived number of toggles; the value 255 distinguishes a compare clear from an overflow. Directed sequences then cover a flag clear colliding with a set, presetting while stopped versus running, and a compare rewrite in mid-period.

// File: rtl/ctt_pkg.sv
// Package ctt_pkg
// Shared constants and register layout for the compare-match timer.
// Assumes an 8-bit register port and two event kinds (compare, overflow).
package ctt_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int NUM_EV = 2;
    localparam int EV_CMP = 0;
    localparam int EV_OVF = 1;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP   = 3'd2;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAG  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd5;

    // Control register, bit 0 is the run bit, bit 7 is a spare storage bit
    typedef struct packed {
        logic spare;
        logic flag_ovf;
        logic flag_cmp;
        logic tog_ovf;
        logic tog_cmp;
        logic clr_cmp;
        logic preset;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/ctt_prescaler.sv
// Module ctt_prescaler
// Picks one of NSRC source pulses and passes every 2^expo-th of them on.
// Assumes source pulses are single-cycle enables and 2^EXP_W-1 <= PRE_W.
// The phase counter is held at zero while the timer is stopped.
module ctt_prescaler #(
    parameter int NSRC  = 4,
    parameter int PRE_W = 15,
    parameter int EXP_W = 4,
    localparam int SEL_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic [EXP_W-1:0] expo,
    output logic             tick
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] last_phase;
    logic             src_hit;

    // Terminal phase value: 2^expo - 1 as a mask of ones
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            last_phase[i] = (i < int'(expo));
        end
    end

    // Selected source, seen only while running
    assign src_hit = run & src_tick[sel];
    assign tick    = src_hit & (phase_q == last_phase);

    // Phase counter: wraps at the terminal value, cleared while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
        end else if (src_hit) begin
            phase_q <= (phase_q == last_phase) ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/ctt_counter.sv
// Module ctt_counter
// Up counter with compare detection and optional clear on compare.
// Assumes tick is a one-cycle enable already qualified by the run bit.
// Events are combinational and valid only in the cycle of the tick.
module ctt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             clr_on_cmp,
    output logic [CNT_W-1:0] count,
    output logic             cmp_hit,
    output logic             ovf_hit
);

    logic cleared;

    // Event decode for the current step
    assign cmp_hit = tick & (count == cmp_val);
    assign cleared = cmp_hit & clr_on_cmp;
    assign ovf_hit = tick & (count == {CNT_W{1'b1}}) & ~cleared;

    // Count register: clear on compare wins over increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            count <= cleared ? '0 : count + 1'b1;
        end
    end

endmodule

// File: rtl/ctt_wave.sv
// Module ctt_wave
// Toggle flip-flop and stage pulse driven by the enabled events.
// Assumes preset_ld is raised only while the timer is stopped, so it
// never coincides with a toggle.
module ctt_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_hit,
    input  logic ovf_hit,
    input  logic tog_cmp,
    input  logic tog_ovf,
    input  logic preset_ld,
    input  logic preset_val,
    output logic wave,
    output logic stage_clk
);

    logic flip;

    assign flip = (cmp_hit & tog_cmp) | (ovf_hit & tog_ovf);

    // Stage pulse follows the toggle decision by one register
    always_ff @(posedge clk) begin
        if (!rst_n) stage_clk <= 1'b0;
        else        stage_clk <= flip;
    end

    // Wave level: preset load, else invert on toggle
    always_ff @(posedge clk) begin
        if (!rst_n)         wave <= 1'b0;
        else if (preset_ld) wave <= preset_val;
        else if (flip)      wave <= ~wave;
    end

endmodule

// File: rtl/ctt_irq.sv
// Module ctt_irq
// Sticky per-event flags with write-one-to-clear and mask gating.
// Assumes set and clr are one-cycle pulses; set wins when both occur.
module ctt_irq #(
    parameter int NEV = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] set,
    input  logic [NEV-1:0] clr,
    input  logic [NEV-1:0] mask,
    output logic [NEV-1:0] flag,
    output logic [NEV-1:0] irq
);

    for (genvar e = 0; e < NEV; e++) begin : g_ev
        // One flag: set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)      flag[e] <= 1'b0;
            else if (set[e]) flag[e] <= 1'b1;
            else if (clr[e]) flag[e] <= 1'b0;
        end
        assign irq[e] = flag[e] & mask[e];
    end

endmodule

// File: rtl/cmp_toggle_timer.sv
// Module cmp_toggle_timer
// Top of the compare-match timer: register port, prescaler, counter,
// toggle output and interrupt flags. Assumes CNT_W <= DATA_W and
// SEL_W + EXP_W <= DATA_W. Count readback is meaningful while stopped.
module cmp_toggle_timer
    import ctt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int NSRC  = 4,
    parameter int PRE_W = 15,
    parameter int EXP_W = 4,
    localparam int SEL_W = $clog2(NSRC),
    localparam int MODE_W = SEL_W + EXP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wave_out,
    output logic              stage_clk,
    output logic              irq_cmp,
    output logic              irq_ovf
);

    ctrl_t             ctrl_q;
    logic [SEL_W-1:0]  sel_q;
    logic [EXP_W-1:0]  expo_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [NUM_EV-1:0] mask_q;
    logic [NUM_EV-1:0] flag_q;
    logic [NUM_EV-1:0] flag_set;
    logic [NUM_EV-1:0] flag_clr;
    logic [NUM_EV-1:0] irq_v;
    logic [CNT_W-1:0]  count;
    logic              run;
    logic              tick;
    logic              cmp_hit;
    logic              ovf_hit;
    logic              wr_ctrl;
    logic              preset_ld;

    assign run       = ctrl_q.run;
    assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    assign preset_ld = wr_ctrl && !ctrl_q.run;

    // Software-written configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sel_q  <= '0;
            expo_q <= '0;
            cmp_q  <= '0;
            mask_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL:  ctrl_q <= ctrl_t'(reg_wdata);
                A_MODE:  {expo_q, sel_q} <= reg_wdata[MODE_W-1:0];
                A_CMP:   cmp_q  <= reg_wdata[CNT_W-1:0];
                A_MASK:  mask_q <= reg_wdata[NUM_EV-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer, zero-extended to the port width
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = ctrl_q;
            A_MODE:  reg_rdata = DATA_W'({expo_q, sel_q});
            A_CMP:   reg_rdata = DATA_W'(cmp_q);
            A_COUNT: reg_rdata = DATA_W'(count);
            A_FLAG:  reg_rdata = DATA_W'(flag_q);
            A_MASK:  reg_rdata = DATA_W'(mask_q);
            default: reg_rdata = '0;
        endcase
    end

    // Flag set and write-one-to-clear requests
    always_comb begin
        flag_set         = '0;
        flag_set[EV_CMP] = cmp_hit & ctrl_q.flag_cmp;
        flag_set[EV_OVF] = ovf_hit & ctrl_q.flag_ovf;
        flag_clr = (reg_wr && reg_addr == A_FLAG) ? reg_wdata[NUM_EV-1:0] : '0;
    end

    ctt_prescaler #(
        .NSRC  (NSRC),
        .PRE_W (PRE_W),
        .EXP_W (EXP_W)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .src_tick (src_tick),
        .sel      (sel_q),
        .expo     (expo_q),
        .tick     (tick)
    );

    ctt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cmp_val    (cmp_q),
        .clr_on_cmp (ctrl_q.clr_cmp),
        .count      (count),
        .cmp_hit    (cmp_hit),
        .ovf_hit    (ovf_hit)
    );

    ctt_wave u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_hit    (cmp_hit),
        .ovf_hit    (ovf_hit),
        .tog_cmp    (ctrl_q.tog_cmp),
        .tog_ovf    (ctrl_q.tog_ovf),
        .preset_ld  (preset_ld),
        .preset_val (reg_wdata[1]),
        .wave       (wave_out),
        .stage_clk  (stage_clk)
    );

    ctt_irq #(
        .NEV (NUM_EV)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .mask  (mask_q),
        .flag  (flag_q),
        .irq   (irq_v)
    );

    assign irq_cmp = irq_v[EV_CMP];
    assign irq_ovf = irq_v[EV_OVF];

endmodule

// File: rtl/ctt_checker.sv
// Module ctt_checker
// Temporal properties of the timer, attached to the top by bind.
// Assumes it sees the top's run bit, count, flags and clear requests.
module ctt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [CNT_W-1:0] count,
    input logic             wave,
    input logic             stage_clk,
    input logic [1:0]       flags,
    input logic [1:0]       flag_clr,
    input logic             irq_cmp,
    input logic             irq_ovf
);

    assert_count_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> count == $past(count));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)
                 || count == '0));

    assert_wave_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (stage_clk == (wave != $past(wave))));

    assert_stage_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stage_clk |-> $past(run));

    assert_cmp_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !flag_clr[0]) |=> flags[0]);

    assert_ovf_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !flag_clr[1]) |=> flags[1]);

    assert_cmp_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cmp |-> flags[0]);

    assert_ovf_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> flags[1]);

endmodule

bind cmp_toggle_timer ctt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .count     (count),
    .wave      (wave_out),
    .stage_clk (stage_clk),
    .flags     (flag_q),
    .flag_clr  (flag_clr),
    .irq_cmp   (irq_cmp),
    .irq_ovf   (irq_ovf)
);

// File: tb/cmp_toggle_timer_tb.sv
// Bench for cmp_toggle_timer: sweeps with an arithmetic reference model.
module cmp_toggle_timer_tb;
    import ctt_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_tick = '0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = A_COUNT;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       wave_out, stage_clk, irq_cmp, irq_ovf;

    int checks = 0;
    int errors = 0;

    // Reference state
    int m_cnt, m_cmp, m_sel, m_k, m_pc, m_im;
    bit m_wave, m_stage, m_fc, m_fo;
    bit m_en, m_clr, m_tc, m_to, m_ic, m_io;

    always #5 clk = ~clk;

    cmp_toggle_timer u_dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wave_out(wave_out), .stage_clk(stage_clk),
        .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_addr = A_COUNT;
        #1;
    endtask

    task automatic model_reset();
        m_cnt = 0; m_cmp = 0; m_sel = 0; m_k = 0; m_pc = 0; m_im = 0;
        m_wave = 0; m_stage = 0; m_fc = 0; m_fo = 0;
        m_en = 0; m_clr = 0; m_tc = 0; m_to = 0; m_ic = 0; m_io = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // One counter step as the requirements describe it
    task automatic model_step();
        bit cev, oev;
        cev = (m_cnt == m_cmp);
        if (cev && m_clr) begin
            m_cnt = 0;
            oev = 0;
        end else begin
            oev = (m_cnt == 255);
            m_cnt = (m_cnt + 1) % 256;
        end
        m_stage = (cev && m_tc) || (oev && m_to);
        if (m_stage) m_wave = !m_wave;
        if (cev && m_ic) m_fc = 1;
        if (oev && m_io) m_fo = 1;
    endtask

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        case (a)
            A_CTRL: begin
                if (!m_en) m_wave = d[1];
                m_en = d[0]; m_clr = d[2]; m_tc = d[3]; m_to = d[4];
                m_ic = d[5]; m_io = d[6];
                if (!m_en) m_pc = 0;
            end
            A_MODE: begin m_sel = int'(d[1:0]); m_k = int'(d[5:2]); end
            A_CMP:  m_cmp = int'(d);
            A_FLAG: begin if (d[0]) m_fc = 0; if (d[1]) m_fo = 0; end
            A_MASK: m_im = int'(d[1:0]);
            default: ;
        endcase
    endtask

    task automatic check_state(input string tag);
        check({tag, " count"}, reg_rdata, m_cnt);
        check("R7 wave level", wave_out, m_wave);
        check("R7 stage pulse", stage_clk, m_stage);
        check("R9 compare line", irq_cmp, m_fc & m_im[0]);
        check("R9 overflow line", irq_ovf, m_fo & m_im[1]);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        m_stage = 0;
        model_write(a, d);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_COUNT;
    endtask

    task automatic pulse(input int s, input string tag);
        src_tick = 4'(1 << s);
        m_stage = 0;
        if (m_en && s == m_sel) begin
            if (m_pc == (1 << m_k) - 1) begin
                m_pc = 0;
                model_step();
            end else begin
                m_pc++;
            end
        end
        @(negedge clk);
        src_tick = '0;
        check_state(tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int cmp_list[8] = '{0, 1, 2, 3, 7, 100, 254, 255};

        // R1: reset state
        do_reset();
        check_state("R1 reset");
        rd(A_CTRL, v);  check("R1 control", v, 0);
        rd(A_MODE, v);  check("R1 mode", v, 0);
        rd(A_CMP, v);   check("R1 compare", v, 0);
        rd(A_FLAG, v);  check("R1 flags", v, 0);
        rd(A_MASK, v);  check("R1 mask", v, 0);

        // R2/R3: every source and exponents 0..2
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 3; k++) begin
                wr(A_CTRL, 8'h00);
                wr(A_MODE, 8'((k << 2) | s));
                wr(A_CTRL, 8'h01);
                for (int o = 0; o < 4; o++)
                    if (o != s) pulse(o, "R2 unselected source");
                for (int n = 0; n < 3 * (1 << k); n++)
                    pulse(s, "R3 prescaled step");
            end
        end

        // R4: stopped counter ignores pulses
        wr(A_CTRL, 8'h00);
        for (int n = 0; n < 5; n++) pulse(m_sel, "R4 frozen");
        for (int n = 0; n < 4; n++) pulse(n, "R4 any source");

        // R5: full free-running lap with overflow actions only
        do_reset();
        wr(A_MASK, 8'h02);
        wr(A_CTRL, 8'h51);
        for (int n = 0; n < 260; n++) pulse(0, "R5 lap");
        rd(A_FLAG, v);
        check("R5 overflow flag", v[1], 1);
        check("R8 compare flag stays clear without its control bit", v[0], 0);
        check("R7 wave after one wrap", wave_out, 1);

        // R6: clear on compare over a spread of compare values
        foreach (cmp_list[i]) begin
            int c, steps;
            c = cmp_list[i];
            steps = 2 * (c + 1) + 2;
            do_reset();
            wr(A_CMP, 8'(c));
            wr(A_CTRL, 8'h2D);
            for (int n = 0; n < steps; n++) pulse(0, "R6 clear period");
            check("R6 count after laps", reg_rdata, steps % (c + 1));
            check("R6 toggles per period", wave_out, (steps / (c + 1)) % 2);
        end

        // R8/R9: flag from last run (compare 255, no overflow)
        rd(A_FLAG, v);
        check("R6 no overflow at clear from 255", v[1], 0);
        check("R8 compare flag latched", v[0], 1);
        check("R9 masked off", irq_cmp, 0);
        wr(A_MASK, 8'h01);
        check("R9 mask on", irq_cmp, 1);
        wr(A_FLAG, 8'h02);
        rd(A_FLAG, v);
        check("R8 zero bit leaves flag", v[0], 1);
        wr(A_FLAG, 8'h01);
        rd(A_FLAG, v);
        check("R8 write one clears", v[0], 0);
        check("R9 line drops", irq_cmp, 0);

        // R8: clear in the same cycle as a compare event
        do_reset();
        wr(A_CMP, 8'd2);
        wr(A_CTRL, 8'h21);
        pulse(0, "R8 approach");
        pulse(0, "R8 approach");
        wr(A_FLAG, 8'h01);
        reg_wr = 1'b1; reg_addr = A_FLAG; reg_wdata = 8'h01; src_tick = 4'b0001;
        model_write(A_FLAG, 8'h01);
        model_step();
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_COUNT; src_tick = '0;
        rd(A_FLAG, v);
        check("R8 set wins over clear", v[0], 1);

        // R10: preset only while stopped
        do_reset();
        wr(A_CTRL, 8'h02);
        check("R10 preset high", wave_out, 1);
        wr(A_CTRL, 8'h01);
        check("R10 start loads preset low", wave_out, 0);
        wr(A_CTRL, 8'h03);
        check("R10 ignored while running", wave_out, 0);
        wr(A_CTRL, 8'h00);
        wr(A_CTRL, 8'h02);
        check("R10 preset after stop", wave_out, 1);

        // R11: compare rewrite while running
        do_reset();
        wr(A_CMP, 8'd10);
        wr(A_CTRL, 8'h05);
        for (int n = 0; n < 3; n++) pulse(0, "R11 run");
        wr(A_CMP, 8'd5);
        for (int n = 0; n < 3; n++) pulse(0, "R11 new compare");
        check("R11 clear at new value", reg_rdata, 0);
        wr(A_CTRL, 8'h00);
        rd(A_COUNT, v);
        check("R12 readback while stopped", v, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule